// File: doc/BRIEF.md
# Undocumented-Operation ALU Extension

This unit evaluates the result of the unofficial 8-bit processor operations that combine a logic step with a load, a shift or a masked store, for binary arithmetic only. The sequencer that has already decoded the instruction and formed the effective address presents one operation select together with the accumulator, both index registers, the stack pointer, the current N, Z, C and V flags, the byte fetched from memory and the high byte of the effective address. One cycle later the unit returns the new register values, the byte to be stored, a write enable for each destination, and the updated flags.

Each accepted request produces exactly one result, marked by `out_valid`, in the following cycle. A request can be issued on every cycle. Register outputs that an operation does not write repeat their input values. Flags that an operation does not touch pass through unchanged.

Top module: `undoc_alu`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `a_we`, `x_we`, `s_we` and `mem_we` are low.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. The write enables are only high when `out_valid` is high.
- R3: Masked stores (op 0 stores A&X&(hi+1), op 1 stores X&(hi+1), op 2 stores Y&(hi+1), where hi+1 wraps to 8 bits) raise `mem_we` only and leave every flag unchanged.
- R4: Op 3 loads S with A&X (`s_we`) and stores A&X&(hi+1) (`mem_we`). Flags are unchanged.
- R5: Op 4 loads data&S into A, X and S (all three enables).
- R6: Op 5 loads (A|0xEE)&X&data into A. Op 6 loads (A|0xEE)&data into both A and X.
- R7: Op 7 forms t=A&data, loads t>>1 into A and sets C to bit 0 of t.
- R8: Op 8 loads A&data into A and sets C to bit 7 of the result.
- R9: Op 9 forms t=A&data and loads {C_in, t[7:1]} into A. The new C is bit 6 of the result and the new V is bit 6 XOR bit 5 of the result.
- R10: Every op that loads A or X sets N to bit 7 and Z to (result==0). N, Z, C and V are otherwise kept unless R7 to R9 name them.
- R11: Op codes 10 to 15 write nothing and return all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation select (codes per R3 to R11) |
| a_in | input | 8 | Accumulator |
| x_in | input | 8 | Index register X |
| y_in | input | 8 | Index register Y |
| s_in | input | 8 | Stack pointer |
| data_in | input | 8 | Fetched memory byte |
| addr_hi | input | 8 | Effective address high byte |
| n_in | input | 1 | Current N flag |
| z_in | input | 1 | Current Z flag |
| c_in | input | 1 | Current C flag |
| v_in | input | 1 | Current V flag |
| out_valid | output | 1 | Result strobe |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New X |
| s_out | output | 8 | New stack pointer |
| store_data | output | 8 | Byte to write to memory |
| a_we | output | 1 | Write accumulator |
| x_we | output | 1 | Write X |
| s_we | output | 1 | Write stack pointer |
| mem_we | output | 1 | Write memory |
| n_out | output | 1 | New N flag |
| z_out | output | 1 | New Z flag |
| c_out | output | 1 | New C flag |
| v_out | output | 1 | New V flag |

## Verification
On every cycle the assertions check the one-cycle valid latency and the enable gating. They also check that a store never also writes A or X, that the stack load keeps the stored byte inside the new S, that the three-way load leaves A, X and S equal, and that Z follows a written accumulator. The exact values, such as the 0xEE mask, the wrap of hi+1 at 0xFF, and the carry and overflow rules of the shift and rotate ops, can only be shown by the bench. The bench compares directed corner cases and random operands against its own model.

// File: rtl/undoc_alu.sv
module undoc_alu #(
  parameter int W = 8,
  parameter int OPW = 4,
  parameter logic [W-1:0] ORMASK = 8'hEE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   y_in,
  input  logic [W-1:0]   s_in,
  input  logic [W-1:0]   data_in,
  input  logic [W-1:0]   addr_hi,
  input  logic           n_in,
  input  logic           z_in,
  input  logic           c_in,
  input  logic           v_in,
  output logic           out_valid,
  output logic [W-1:0]   a_out,
  output logic [W-1:0]   x_out,
  output logic [W-1:0]   s_out,
  output logic [W-1:0]   store_data,
  output logic           a_we,
  output logic           x_we,
  output logic           s_we,
  output logic           mem_we,
  output logic           n_out,
  output logic           z_out,
  output logic           c_out,
  output logic           v_out
);
  localparam logic [OPW-1:0] OP_STAX = 0, OP_STX = 1, OP_STY = 2, OP_STSP = 3,
                             OP_LDSP = 4, OP_MAGA = 5, OP_MAGAX = 6,
                             OP_ANDSR = 7, OP_ANDC = 8, OP_ANDROR = 9;

  logic [W-1:0] hi_inc, ax, masked, res;
  logic [W-1:0] na, nx, ns, nst;
  logic wa, wx, ws, wm, upd_nz, nn, nz, nc, nv;

  assign hi_inc = addr_hi + 1'b1;
  assign ax     = a_in & x_in;
  assign masked = a_in & data_in;

  always_comb begin
    na = a_in; nx = x_in; ns = s_in; nst = '0; res = '0;
    wa = 1'b0; wx = 1'b0; ws = 1'b0; wm = 1'b0; upd_nz = 1'b0;
    nn = n_in; nz = z_in; nc = c_in; nv = v_in;
    case (op)
      OP_STAX:  begin nst = ax & hi_inc; wm = 1'b1; end
      OP_STX:   begin nst = x_in & hi_inc; wm = 1'b1; end
      OP_STY:   begin nst = y_in & hi_inc; wm = 1'b1; end
      OP_STSP:  begin ns = ax; ws = 1'b1; nst = ax & hi_inc; wm = 1'b1; end
      OP_LDSP:  begin
        res = data_in & s_in;
        na = res; nx = res; ns = res;
        wa = 1'b1; wx = 1'b1; ws = 1'b1; upd_nz = 1'b1;
      end
      OP_MAGA:  begin res = (a_in | ORMASK) & x_in & data_in; na = res; wa = 1'b1; upd_nz = 1'b1; end
      OP_MAGAX: begin
        res = (a_in | ORMASK) & data_in;
        na = res; nx = res; wa = 1'b1; wx = 1'b1; upd_nz = 1'b1;
      end
      OP_ANDSR: begin res = masked >> 1; nc = masked[0]; na = res; wa = 1'b1; upd_nz = 1'b1; end
      OP_ANDC:  begin res = masked; nc = masked[W-1]; na = res; wa = 1'b1; upd_nz = 1'b1; end
      OP_ANDROR: begin
        res = {c_in, masked[W-1:1]};
        nc = res[W-2];
        nv = res[W-2] ^ res[W-3];
        na = res; wa = 1'b1; upd_nz = 1'b1;
      end
      default: ;
    endcase
    if (upd_nz) begin
      nn = res[W-1];
      nz = (res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      a_we <= 1'b0; x_we <= 1'b0; s_we <= 1'b0; mem_we <= 1'b0;
      a_out <= '0; x_out <= '0; s_out <= '0; store_data <= '0;
      n_out <= 1'b0; z_out <= 1'b0; c_out <= 1'b0; v_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      a_we <= in_valid & wa;
      x_we <= in_valid & wx;
      s_we <= in_valid & ws;
      mem_we <= in_valid & wm;
      if (in_valid) begin
        a_out <= na; x_out <= nx; s_out <= ns; store_data <= nst;
        n_out <= nn; z_out <= nz; c_out <= nc; v_out <= nv;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_we_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (a_we || x_we || s_we || mem_we) |-> out_valid);
  p_store_no_reg_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!a_we && !x_we));
  p_stack_store_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && s_we) |-> ((store_data & ~s_out) == '0));
  p_triple_load_r5: assert property (@(posedge clk) disable iff (rst)
    (a_we && x_we && s_we) |-> (a_out == x_out && x_out == s_out));
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (rst)
    a_we |-> (z_out == (a_out == '0)));
endmodule

// File: tb/sim_undoc_alu.sv
module sim_undoc_alu;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a_in = '0, x_in = '0, y_in = '0, s_in = '0, data_in = '0, addr_hi = '0;
  logic n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
  logic out_valid, a_we, x_we, s_we, mem_we, n_out, z_out, c_out, v_out;
  logic [7:0] a_out, x_out, s_out, store_data;

  always #10 clk = ~clk;

  undoc_alu u0 (.clk, .rst, .in_valid, .op, .a_in, .x_in, .y_in, .s_in, .data_in,
    .addr_hi, .n_in, .z_in, .c_in, .v_in, .out_valid, .a_out, .x_out, .s_out,
    .store_data, .a_we, .x_we, .s_we, .mem_we, .n_out, .z_out, .c_out, .v_out);

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a, x, s, st;
    logic [3:0] we;
    logic [3:0] fl;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic string tag(input logic [3:0] o);
    case (o)
      0, 1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [7:0] a, x, y, s, d, hi,
                                 input logic n, z, c, v);
    exp_t e;
    logic [7:0] p, t;
    logic ld;
    p = hi + 8'd1;
    e.op = o; e.a = a; e.x = x; e.s = s; e.st = 8'h00; e.we = 4'b0000;
    e.fl = {n, z, c, v};
    ld = 1'b0; t = 8'h00;
    if (o == 0) begin e.st = a & x & p; e.we = 4'b0001; end
    else if (o == 1) begin e.st = x & p; e.we = 4'b0001; end
    else if (o == 2) begin e.st = y & p; e.we = 4'b0001; end
    else if (o == 3) begin e.s = x & a; e.st = e.s & p; e.we = 4'b0011; end
    else if (o == 4) begin t = s & d; e.a = t; e.x = t; e.s = t; e.we = 4'b1110; ld = 1; end
    else if (o == 5) begin t = d & x & (a | 8'hEE); e.a = t; e.we = 4'b1000; ld = 1; end
    else if (o == 6) begin t = d & (a | 8'hEE); e.a = t; e.x = t; e.we = 4'b1100; ld = 1; end
    else if (o == 7) begin t = (a & d) / 2; e.fl[1] = a[0] & d[0]; e.a = t; e.we = 4'b1000; ld = 1; end
    else if (o == 8) begin t = a & d; e.fl[1] = t[7]; e.a = t; e.we = 4'b1000; ld = 1; end
    else if (o == 9) begin
      t = ((a & d) >> 1) | (c ? 8'h80 : 8'h00);
      e.fl[1] = t[6]; e.fl[0] = t[6] != t[5];
      e.a = t; e.we = 4'b1000; ld = 1;
    end
    if (ld) begin e.fl[3] = t[7]; e.fl[2] = (t == 8'h00); end
    return e;
  endfunction

  task automatic issue(input logic [3:0] o, input logic [7:0] a, x, y, s, d, hi,
                       input logic n, z, c, v);
    @(negedge clk);
    op = o; a_in = a; x_in = x; y_in = y; s_in = s; data_in = d; addr_hi = hi;
    n_in = n; z_in = z; c_in = c; v_in = v; in_valid = 1'b1;
    sb.push_back(model(o, a, x, y, s, d, hi, n, z, c, v));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: out_valid=1 expected 0 (no pending request)");
      end else begin
        e = sb.pop_front();
        if ({a_out, x_out, s_out, store_data} != {e.a, e.x, e.s, e.st}) begin
          errors++;
          $display("FAIL %s op=%0d: a/x/s/st=%h %h %h %h expected %h %h %h %h", tag(e.op), e.op,
                   a_out, x_out, s_out, store_data, e.a, e.x, e.s, e.st);
        end
        if ({a_we, x_we, s_we, mem_we} != e.we) begin
          errors++;
          $display("FAIL %s op=%0d: enables=%b expected %b", tag(e.op), e.op,
                   {a_we, x_we, s_we, mem_we}, e.we);
        end
        if ({n_out, z_out, c_out, v_out} != e.fl) begin
          errors++;
          $display("FAIL R10/%s op=%0d: NZCV=%b expected %b", tag(e.op), e.op,
                   {n_out, z_out, c_out, v_out}, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, a_we, x_we, s_we, mem_we} != 5'b0) begin
      errors++;
      $display("FAIL R1: valid/enables=%b expected 00000 in reset",
               {out_valid, a_we, x_we, s_we, mem_we});
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({out_valid, a_we, x_we, s_we, mem_we} != 5'b0) begin
      errors++;
      $display("FAIL R1: valid/enables=%b expected 00000 after reset",
               {out_valid, a_we, x_we, s_we, mem_we});
    end
    // R3 directed, including wrap of hi+1
    issue(0, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h12, 1, 0, 1, 0);
    issue(1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 1, 0, 1);
    issue(2, 8'h00, 8'h00, 8'hF7, 8'h00, 8'h00, 8'h7F, 0, 0, 0, 0);
    // R4 / R5
    issue(3, 8'hF3, 8'h3F, 8'h00, 8'h11, 8'h00, 8'h0F, 1, 1, 0, 0);
    issue(4, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0F, 8'h00, 1, 0, 1, 1);
    idle();
    checks++;
    idle();
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2: out_valid=%b expected 0 after idle", out_valid);
    end
    // R6 magic mask
    issue(5, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0);
    issue(6, 8'h01, 8'h00, 8'h00, 8'h00, 8'h11, 8'h00, 1, 1, 1, 1);
    // R7 carry from bit 0 before shift
    issue(7, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 1, 1, 0, 0);
    // R8
    issue(8, 8'h80, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h00, 0, 1, 0, 0);
    // R9 carry/overflow corners
    issue(9, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 1, 0);
    issue(9, 8'h40, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0);
    issue(9, 8'h01, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1, 0, 0, 1);
    // R11 unused codes
    issue(12, 8'h55, 8'hAA, 8'h33, 8'hCC, 8'hFF, 8'h10, 1, 0, 1, 0);
    issue(15, 8'h55, 8'hAA, 8'h33, 8'hCC, 8'hFF, 8'h10, 0, 1, 0, 1);
    // random sweep over every op code, with gaps
    for (int i = 0; i < 600; i++) begin
      issue(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    idle();
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: pending=%0d expected 0", sb.size());
    end
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2: watchdog expired=1 expected 0");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule